// File: doc/BRIEF.md
# Prioritised Nesting Interrupt Controller

This block sits between a set of device interrupt lines and a processor core. Each device line raises a request pulse. The controller records that pulse in a single pending flag for the device. It then chooses, from the devices that are both pending and enabled, the one with the most urgent priority. That choice is offered to the core only when the core may take it: the global mask must be clear, and the candidate must be strictly more urgent than the handler that is running now.

The core reports each handler entry with the device number and each handler return with a strobe. The controller keeps a small stack of the priority levels of the nested handlers. The top of that stack is the current execution level. A device whose handler is running is never offered again until that handler returns.

Software changes the per-device enables through set and clear strobe vectors and rewrites priorities one device at a time. State the controller leaves out: exception stacking in the core and system exceptions.

Top module: `irq_ctrl`

## Requirements
- R1: After reset no device is pending or enabled, every priority is 0, the nesting stack is empty and `req_o` is 0.
- R2: A high bit in `irq_pulse_i` sets that device's pending flag on the next edge. Further pulses before the handler entry merge into that one flag, so exactly one presentation results.
- R3: `req_o` is 1 only for a device that is pending, enabled and not in its own handler, and whose priority is strictly below the current execution level. `req_id_o` gives that device's number.
- R4: Among the eligible devices, the lowest priority value wins (0 is the most urgent). Equal priorities go to the lowest device number.
- R5: While `gmask_i` is 1, `req_o` stays 0 but pulses are still recorded. Clearing the mask presents the held request in the same cycle.
- R6: A pulse on a disabled device is held as pending and is presented once the device is enabled. When `en_set_i` and `en_clr_i` hit the same bit in one cycle, the clear wins.
- R7: `entry_i` with `entry_id_i` clears that device's pending flag and pushes its priority onto the nesting stack. The stack holds up to `NEST_DEPTH` levels. An empty stack means idle level 4, below every priority.
- R8: While a handler runs, only a strictly more urgent priority is presented. An equal or less urgent one waits.
- R9: A device is never presented while its own handler is active, even if its priority is rewritten to be more urgent.
- R10: `exit_i` pops the top level. Any request that was held back by that level is presented right after the pop.
- R11: A pulse for a device in the same cycle as entry to that device's handler leaves its pending flag set. It is presented after the handler exits.
- R12: `prio_we_i` writes `prio_val_i` into device `prio_idx_i` at the next edge. The new value takes part in selection from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pulse_i | input | N_IRQ | Device request pulses, one bit per device |
| en_set_i | input | N_IRQ | Write-one-to-set device enables |
| en_clr_i | input | N_IRQ | Write-one-to-clear device enables |
| prio_we_i | input | 1 | Priority write strobe |
| prio_idx_i | input | ID_W | Device number for the priority write |
| prio_val_i | input | 2 | Priority value, 0 most urgent |
| gmask_i | input | 1 | Global mask, 1 blocks all requests to the core |
| entry_i | input | 1 | Core enters a handler |
| entry_id_i | input | ID_W | Device whose handler is entered |
| exit_i | input | 1 | Core returns from the innermost handler |
| req_o | output | 1 | Request to the core |
| req_id_o | output | ID_W | Selected device number, valid while req_o is 1 |

## Verification
The two functions that can fall in the same cycle are a device's new request pulse and the core's entry into that device's handler. One wants the pending flag set and the other wants it cleared. The bench drives both strobes for the same device in one cycle. It then checks that no request appears while the handler runs, and that exactly one request for that device appears after the exit strobe. This shows the new pulse survived the entry. A second pairing, enable set and enable clear on the same bit, is judged by which device is offered afterwards.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [PRIO_W:0]   xprio_t;
    localparam xprio_t IDLE_LEVEL = xprio_t'(1 << PRIO_W);

    function automatic xprio_t widen(input prio_t p);
        return {1'b0, p};
    endfunction
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 48,
    parameter int ID_W  = 6
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_IRQ-1:0]       irq_pulse_i,
    input  logic [N_IRQ-1:0]       en_set_i,
    input  logic [N_IRQ-1:0]       en_clr_i,
    input  logic                   prio_we_i,
    input  logic [ID_W-1:0]        prio_idx_i,
    input  prio_t                  prio_val_i,
    input  logic                   entry_i,
    input  logic [ID_W-1:0]        entry_id_i,
    input  logic                   exit_i,
    input  logic [ID_W-1:0]        exit_id_i,
    output logic [N_IRQ-1:0]       pend_o,
    output logic [N_IRQ-1:0]       en_o,
    output logic [N_IRQ-1:0]       act_o,
    output prio_t [N_IRQ-1:0]      prio_o,
    output prio_t                  entry_prio_o
);
    typedef struct packed {
        logic [N_IRQ-1:0]  pend;
        logic [N_IRQ-1:0]  en;
        logic [N_IRQ-1:0]  act;
        prio_t [N_IRQ-1:0] prio;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d    = bank_q;
        bank_d.en = (bank_q.en | en_set_i) & ~en_clr_i;
        for (int i = 0; i < N_IRQ; i++) begin
            if (entry_i && entry_id_i == ID_W'(i)) begin
                bank_d.pend[i] = 1'b0;
                bank_d.act[i]  = 1'b1;
            end
            if (exit_i && exit_id_i == ID_W'(i)) begin
                bank_d.act[i] = 1'b0;
            end
            // a fresh pulse outranks the clear from handler entry
            if (irq_pulse_i[i]) begin
                bank_d.pend[i] = 1'b1;
            end
            if (prio_we_i && prio_idx_i == ID_W'(i)) begin
                bank_d.prio[i] = prio_val_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        entry_prio_o = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (entry_id_i == ID_W'(i)) begin
                entry_prio_o = bank_q.prio[i];
            end
        end
    end

    assign pend_o = bank_q.pend;
    assign en_o   = bank_q.en;
    assign act_o  = bank_q.act;
    assign prio_o = bank_q.prio;

    assert_pulse_recorded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pulse_i != '0) |=> ((pend_o & $past(irq_pulse_i)) == $past(irq_pulse_i)));

    assert_entry_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_i |-> (int'(entry_id_i) < N_IRQ));

    assert_entry_marks_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_i |=> act_o[$past(entry_id_i)]);
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 48,
    parameter int ID_W  = 6
) (
    input  logic [N_IRQ-1:0]  cand_i,
    input  prio_t [N_IRQ-1:0] prio_i,
    output logic              found_o,
    output logic [ID_W-1:0]   id_o,
    output prio_t             prio_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        prio_o  = '1;
        // ascending scan with strict compare keeps the lower number on ties
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i] < prio_o)) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest
    import irqc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ID_W  = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            entry_i,
    input  logic [ID_W-1:0] entry_id_i,
    input  prio_t           entry_prio_i,
    input  logic            exit_i,
    output xprio_t          level_o,
    output logic [ID_W-1:0] top_id_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        prio_t [DEPTH-1:0]           lvl;
        logic [DEPTH-1:0][ID_W-1:0]  id;
        logic [CNT_W-1:0]            cnt;
    } nest_t;

    nest_t nest_d, nest_q;
    prio_t top_prio;

    always_comb begin
        nest_d = nest_q;
        if (exit_i && nest_q.cnt != '0) begin
            nest_d.cnt = nest_q.cnt - 1'b1;
        end
        if (entry_i && int'(nest_q.cnt) < DEPTH) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (nest_q.cnt == CNT_W'(k)) begin
                    nest_d.lvl[k] = entry_prio_i;
                    nest_d.id[k]  = entry_id_i;
                end
            end
            nest_d.cnt = nest_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nest_q <= '0;
        end else begin
            nest_q <= nest_d;
        end
    end

    always_comb begin
        top_prio = '0;
        top_id_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (nest_q.cnt == CNT_W'(k + 1)) begin
                top_prio = nest_q.lvl[k];
                top_id_o = nest_q.id[k];
            end
        end
        level_o = (nest_q.cnt == '0) ? IDLE_LEVEL : widen(top_prio);
    end

    assert_no_push_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_i |-> (int'(nest_q.cnt) < DEPTH));

    assert_no_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exit_i |-> (nest_q.cnt != '0));

    assert_single_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(entry_i && exit_i));

    assert_push_raises_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_i |-> (widen(entry_prio_i) < level_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IRQ      = 48,
    parameter int NEST_DEPTH = 4,
    localparam int ID_W      = $clog2(N_IRQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_IRQ-1:0] irq_pulse_i,
    input  logic [N_IRQ-1:0] en_set_i,
    input  logic [N_IRQ-1:0] en_clr_i,
    input  logic             prio_we_i,
    input  logic [ID_W-1:0]  prio_idx_i,
    input  logic [1:0]       prio_val_i,
    input  logic             gmask_i,
    input  logic             entry_i,
    input  logic [ID_W-1:0]  entry_id_i,
    input  logic             exit_i,
    output logic             req_o,
    output logic [ID_W-1:0]  req_id_o
);
    logic [N_IRQ-1:0]  pend_vec, en_vec, act_vec, cand_vec;
    prio_t [N_IRQ-1:0] prio_vec;
    prio_t             entry_prio, best_prio;
    logic              best_found;
    logic [ID_W-1:0]   best_id, top_id;
    xprio_t            exec_level;

    irqc_src_bank #(.N_IRQ(N_IRQ), .ID_W(ID_W)) i_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .irq_pulse_i  (irq_pulse_i),
        .en_set_i     (en_set_i),
        .en_clr_i     (en_clr_i),
        .prio_we_i    (prio_we_i),
        .prio_idx_i   (prio_idx_i),
        .prio_val_i   (prio_val_i),
        .entry_i      (entry_i),
        .entry_id_i   (entry_id_i),
        .exit_i       (exit_i),
        .exit_id_i    (top_id),
        .pend_o       (pend_vec),
        .en_o         (en_vec),
        .act_o        (act_vec),
        .prio_o       (prio_vec),
        .entry_prio_o (entry_prio)
    );

    assign cand_vec = pend_vec & en_vec & ~act_vec;

    irqc_pick #(.N_IRQ(N_IRQ), .ID_W(ID_W)) i_pick (
        .cand_i  (cand_vec),
        .prio_i  (prio_vec),
        .found_o (best_found),
        .id_o    (best_id),
        .prio_o  (best_prio)
    );

    irqc_nest #(.DEPTH(NEST_DEPTH), .ID_W(ID_W)) i_nest (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .entry_i      (entry_i),
        .entry_id_i   (entry_id_i),
        .entry_prio_i (entry_prio),
        .exit_i       (exit_i),
        .level_o      (exec_level),
        .top_id_o     (top_id)
    );

    assign req_o    = best_found && !gmask_i && (widen(best_prio) < exec_level);
    assign req_id_o = best_id;

    assert_req_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (pend_vec[req_id_o] && en_vec[req_id_o]));

    assert_preempt_strict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (widen(prio_vec[req_id_o]) < exec_level));

    assert_not_own_handler_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> !act_vec[req_id_o]);

    assert_mask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gmask_i) |-> !req_o);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int N    = 48;
    localparam int ID_W = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_pulse = '0;
    logic [N-1:0]    en_set = '0;
    logic [N-1:0]    en_clr = '0;
    logic            prio_we = 1'b0;
    logic [ID_W-1:0] prio_idx = '0;
    logic [1:0]      prio_val = '0;
    logic            gmask = 1'b0;
    logic            entry = 1'b0;
    logic [ID_W-1:0] entry_id = '0;
    logic            exit_s = 1'b0;
    logic            req;
    logic [ID_W-1:0] req_id;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    irq_ctrl #(.N_IRQ(N), .NEST_DEPTH(4)) i_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .irq_pulse_i(irq_pulse),
        .en_set_i(en_set), .en_clr_i(en_clr), .prio_we_i(prio_we),
        .prio_idx_i(prio_idx), .prio_val_i(prio_val), .gmask_i(gmask),
        .entry_i(entry), .entry_id_i(entry_id), .exit_i(exit_s),
        .req_o(req), .req_id_o(req_id)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic exp_req, input int exp_id);
        #1;
        n_checks++;
        if (req !== exp_req || (exp_req && int'(req_id) != exp_id)) begin
            n_fails++;
            $display("FAIL %s: req=%0b id=%0d, expected req=%0b id=%0d",
                     tag, req, req_id, exp_req, exp_id);
        end
    endtask

    task automatic pulse(input int id);
        irq_pulse[id] = 1'b1; tick(); irq_pulse = '0;
    endtask

    task automatic enable(input int id);
        en_set[id] = 1'b1; tick(); en_set = '0;
    endtask

    task automatic set_prio(input int id, input int v);
        prio_we = 1'b1; prio_idx = ID_W'(id); prio_val = 2'(v);
        tick(); prio_we = 1'b0;
    endtask

    task automatic enter(input int id);
        entry = 1'b1; entry_id = ID_W'(id); tick(); entry = 1'b0;
    endtask

    task automatic leave();
        exit_s = 1'b1; tick(); exit_s = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset idle", 1'b0, 0);
        pulse(2);
        check("R1 reset leaves devices disabled", 1'b0, 0);
        enable(2);
        check("R1 enabled after pulse", 1'b1, 2);
        enter(2); leave();
    endtask

    task automatic t_disabled_held();
        pulse(5);
        check("R6 disabled pending held", 1'b0, 0);
        enable(5);
        check("R6 presented after enable", 1'b1, 5);
        en_set[6] = 1'b1; en_clr[6] = 1'b1; irq_pulse[6] = 1'b1; tick();
        en_set = '0; en_clr = '0; irq_pulse = '0;
        check("R6 clear beats set", 1'b1, 5);
        enter(5); leave();
        check("R6 device 6 stays disabled", 1'b0, 0);
        enable(6); enter(6); leave();
    endtask

    task automatic t_merge();
        enable(8);
        gmask = 1'b1;
        pulse(8); pulse(8); pulse(8);
        gmask = 1'b0;
        check("R2 merged request presented", 1'b1, 8);
        enter(8);
        check("R7 entry clears pending", 1'b0, 0);
        leave();
        check("R2 only one presentation", 1'b0, 0);
    endtask

    task automatic t_order();
        set_prio(3, 2); set_prio(7, 1); set_prio(9, 1);
        gmask = 1'b1;
        irq_pulse[3] = 1'b1; irq_pulse[7] = 1'b1; irq_pulse[9] = 1'b1; tick();
        irq_pulse = '0;
        enable(3); enable(7); enable(9);
        gmask = 1'b0;
        check("R4 lowest value, lowest number", 1'b1, 7);
        enter(7);
        check("R8 equal priority waits", 1'b0, 0);
        leave();
        check("R10 held request after exit", 1'b1, 9);
        enter(9); leave();
        check("R4 least urgent last", 1'b1, 3);
        enter(3); leave();
    endtask

    task automatic t_nesting();
        set_prio(10, 2); set_prio(11, 1); set_prio(12, 0); set_prio(13, 0);
        enable(10); enable(11); enable(12); enable(13);
        pulse(10); enter(10);
        pulse(11);
        check("R8 more urgent preempts", 1'b1, 11);
        enter(11);
        pulse(12);
        check("R8 most urgent preempts", 1'b1, 12);
        enter(12);
        pulse(13); pulse(10);
        check("R8 equal level blocked at depth 3", 1'b0, 0);
        leave();
        check("R10 pop restores level 0 for 13", 1'b1, 13);
        enter(13); leave();
        check("R10 level 1 blocks prio 2", 1'b0, 0);
        leave();
        check("R9 own handler still active", 1'b0, 0);
        leave();
        check("R10 held device 10 after final exit", 1'b1, 10);
        enter(10); leave();
        check("R10 all serviced", 1'b0, 0);
    endtask

    task automatic t_own();
        set_prio(20, 2); enable(20);
        pulse(20); enter(20);
        set_prio(20, 0);
        pulse(20);
        check("R9 no self preemption after prio raise", 1'b0, 0);
        leave();
        check("R9 accepted after own exit", 1'b1, 20);
        enter(20); leave();
    endtask

    task automatic t_mask();
        enable(30);
        gmask = 1'b1; tick();
        pulse(30);
        check("R5 mask blocks request", 1'b0, 0);
        gmask = 1'b0;
        check("R5 recorded while masked", 1'b1, 30);
        enter(30); leave();
    endtask

    task automatic t_collide();
        enable(31);
        pulse(31);
        check("R11 presented", 1'b1, 31);
        entry = 1'b1; entry_id = ID_W'(31); irq_pulse[31] = 1'b1; tick();
        entry = 1'b0; irq_pulse = '0;
        check("R11 not offered during own handler", 1'b0, 0);
        leave();
        check("R11 pulse at entry survives", 1'b1, 31);
        enter(31); leave();
        check("R11 single follow-up", 1'b0, 0);
    endtask

    task automatic t_prio_write();
        enable(40); enable(41);
        gmask = 1'b1;
        irq_pulse[40] = 1'b1; irq_pulse[41] = 1'b1; tick(); irq_pulse = '0;
        gmask = 1'b0;
        check("R12 tie before write", 1'b1, 40);
        set_prio(40, 1);
        check("R12 rewritten priority reorders", 1'b1, 41);
        enter(41); leave(); enter(40); leave();
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled_held();
        t_merge();
        t_order();
        t_nesting();
        t_own();
        t_mask();
        t_collide();
        t_prio_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule